// File: doc/BRIEF.md
# Backup Power Switchover Controller

This clocked control block chooses the source of a protected supply rail: either the main supply or a backup battery. It never reads a voltage. Analog comparators outside the block each give it one digital flag: the main supply is below the switchover threshold, the battery is higher than the main supply, the main supply is above the reset threshold, or the power-fail sense input is below its reference. The block resynchronises each flag into its clock domain. It holds the current rail selection in one register and drives the control of the external power switch from that register.

The selection has hysteresis. Moving to the battery needs two conditions at the same time: a low main supply and a battery that is higher than the main supply. Moving back needs only one condition: the main supply has recovered above the reset threshold. This returns the rail to the main supply when the reset supply-low condition clears, which is well before any reset-release delay ends downstream. The block also drives an active-low power-fail warning. The warning follows the power-fail comparator, and it is forced active while the main supply is below the switchover threshold.

Top module: `bkp_switchover_ctrl`

## Requirements
- R1: While rst_n is low, batt_sel_o is 0 (rail on main supply) and pfail_n_o is 0 (warning active).
- R2: In main mode, batt_sel_o becomes 1 when vcc_below_sw_i and batt_above_vcc_i are both 1.
- R3: In main mode with vcc_below_sw_i at 0, batt_above_vcc_i at 1 does not change batt_sel_o.
- R4: In main mode with vcc_below_sw_i at 1 and batt_above_vcc_i at 0, batt_sel_o stays 0. It becomes 1 only once batt_above_vcc_i also rises.
- R5: In battery mode, vcc_above_rst_i at 1 returns batt_sel_o to 0, whatever the value of batt_above_vcc_i.
- R6: In battery mode, batt_sel_o stays 1 while vcc_above_rst_i is 0. This holds even after vcc_below_sw_i has cleared.
- R7: pfail_n_o is 0 when pfi_below_ref_i is 1 and 1 when it is 0, as long as vcc_below_sw_i is 0.
- R8: pfail_n_o is 0 whenever vcc_below_sw_i is 1. It follows pfi_below_ref_i again once vcc_below_sw_i returns to 0.
- R9: A change on any flag input appears on the outputs on the third rising clock edge after it: two synchroniser stages and one output register.
- R10: With vcc_below_sw_i held at 0, toggling batt_above_vcc_i any number of times (battery removed or reinserted) never sets batt_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_below_sw_i | input | 1 | Main supply below switchover threshold (asynchronous flag) |
| batt_above_vcc_i | input | 1 | Battery higher than main supply (asynchronous flag) |
| vcc_above_rst_i | input | 1 | Main supply above reset threshold (asynchronous flag) |
| pfi_below_ref_i | input | 1 | Power-fail sense input below reference (asynchronous flag) |
| batt_sel_o | output | 1 | 1 = rail fed from battery, 0 = rail fed from main supply |
| pfail_n_o | output | 1 | Active-low power-fail warning |

## Verification
On every clock, the embedded properties check the following:
- The mode register moves to the battery only when both entry flags are present.
- The mode register leaves battery mode on a recovered supply and otherwise stays there.
- The warning output tracks its two sources one register later.

The bench scenarios are needed for behaviour that depends on a history of inputs. This includes three-edge latency through the synchronisers, dwelling in battery mode while the supply sits between the two thresholds, returning to the main supply with the battery either high or low, and repeated battery removal during normal operation.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

  typedef enum logic {
    RAIL_MAIN = 1'b0,
    RAIL_BATT = 1'b1
  } rail_e;

  // Entry into backup needs a weak main supply and a stronger battery.
  function automatic logic want_backup(input logic below_sw, input logic batt_hi);
    return below_sw & batt_hi;
  endfunction

  // Exit from backup depends solely on recovery above the reset threshold.
  function automatic logic want_main(input logic above_rst);
    return above_rst;
  endfunction

  // Active-low warning: low on a weak sense input or a collapsed supply.
  function automatic logic warn_level_n(input logic below_sw, input logic pfi_low);
    return ~(below_sw | pfi_low);
  endfunction

endpackage

// File: rtl/bkp_flag_sync.sv
module bkp_flag_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[LAST];

  initial begin
    a_r9_min_depth: assert (STAGES >= 2)
      else $error("synchroniser needs at least two stages");
  end

endmodule

// File: rtl/bkp_rail_fsm.sv
module bkp_rail_fsm
  import bkp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic below_sw,
  input  logic batt_hi,
  input  logic above_rst,
  output logic batt_sel
);

  rail_e mode_q, mode_d;

  logic go_batt;
  logic go_main;

  assign go_batt = want_backup(below_sw, batt_hi);
  assign go_main = want_main(above_rst);

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      RAIL_MAIN: if (go_batt) mode_d = RAIL_BATT;
      RAIL_BATT: if (go_main) mode_d = RAIL_MAIN;
      default:   mode_d = RAIL_MAIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= RAIL_MAIN;
    else        mode_q <= mode_d;
  end

  assign batt_sel = (mode_q == RAIL_BATT);

  // R2: both entry flags in main mode lead to battery mode on the next edge
  a_r2_enter_both: assert property (@(posedge clk) disable iff (!rst_n)
    (!batt_sel && below_sw && batt_hi) |=> batt_sel);

  // R3 / R4: without both entry flags the main mode is kept
  a_r3_no_lone_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!batt_sel && !(below_sw && batt_hi)) |=> !batt_sel);

  // R5: recovery above the reset threshold always leaves battery mode
  a_r5_exit_on_rst: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_sel && above_rst) |=> !batt_sel);

  // R6: battery mode persists until the supply recovers
  a_r6_hold_batt: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_sel && !above_rst) |=> batt_sel);

endmodule

// File: rtl/bkp_pfail_out.sv
module bkp_pfail_out
  import bkp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic below_sw,
  input  logic pfi_low,
  output logic pfail_n
);

  logic level_n;

  assign level_n = warn_level_n(below_sw, pfi_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pfail_n <= 1'b0;
    else        pfail_n <= level_n;
  end

  // R8: a collapsed main supply forces the warning active
  a_r8_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    below_sw |=> !pfail_n);

  // R7: sense input low drives the warning active
  a_r7_sense_low: assert property (@(posedge clk) disable iff (!rst_n)
    pfi_low |=> !pfail_n);

  // R7 / R8: healthy supply and sense input release the warning
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_sw && !pfi_low) |=> pfail_n);

endmodule

// File: rtl/bkp_switchover_ctrl.sv
module bkp_switchover_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_below_sw_i,
  input  logic batt_above_vcc_i,
  input  logic vcc_above_rst_i,
  input  logic pfi_below_ref_i,
  output logic batt_sel_o,
  output logic pfail_n_o
);

  localparam int NFLAGS = 4;
  localparam int F_BSW  = 0;
  localparam int F_BHI  = 1;
  localparam int F_RST  = 2;
  localparam int F_PFI  = 3;

  logic [NFLAGS-1:0] raw_flags;
  logic [NFLAGS-1:0] sync_flags;

  assign raw_flags[F_BSW] = vcc_below_sw_i;
  assign raw_flags[F_BHI] = batt_above_vcc_i;
  assign raw_flags[F_RST] = vcc_above_rst_i;
  assign raw_flags[F_PFI] = pfi_below_ref_i;

  bkp_flag_sync #(
    .WIDTH  (NFLAGS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_flags),
    .sync_o  (sync_flags)
  );

  bkp_rail_fsm u_rail (
    .clk       (clk),
    .rst_n     (rst_n),
    .below_sw  (sync_flags[F_BSW]),
    .batt_hi   (sync_flags[F_BHI]),
    .above_rst (sync_flags[F_RST]),
    .batt_sel  (batt_sel_o)
  );

  bkp_pfail_out u_pfail (
    .clk      (clk),
    .rst_n    (rst_n),
    .below_sw (sync_flags[F_BSW]),
    .pfi_low  (sync_flags[F_PFI]),
    .pfail_n  (pfail_n_o)
  );

  // R1: reset holds both outputs in their safe state
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!batt_sel_o && !pfail_n_o));

  // R10: battery selection never starts without a weak supply seen through the synchroniser
  a_r10_no_entry_healthy: assert property (@(posedge clk) disable iff (!rst_n)
    (!batt_sel_o && !sync_flags[F_BSW]) |=> !batt_sel_o);

endmodule

// File: tb/sim_bkp_switchover_ctrl.sv
module sim_bkp_switchover_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic below_sw = 1'b0, batt_hi = 1'b0, above_rst = 1'b0, pfi_low = 1'b0;
  logic batt_sel, pfail_n;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bkp_switchover_ctrl u0 (
    .clk              (clk),
    .rst_n            (rst_n),
    .vcc_below_sw_i   (below_sw),
    .batt_above_vcc_i (batt_hi),
    .vcc_above_rst_i  (above_rst),
    .pfi_below_ref_i  (pfi_low),
    .batt_sel_o       (batt_sel),
    .pfail_n_o        (pfail_n)
  );

  // {below_sw, batt_hi, above_rst, pfi_low, exp_sel, exp_pfail_n}
  localparam int NV = 11;
  localparam logic [5:0] VEC [NV] = '{
    6'b0010_01, // R7 healthy, warning released
    6'b0110_01, // R3 battery higher alone, no switch
    6'b0011_00, // R7 sense low, warning active
    6'b1000_00, // R4 weak supply, battery lower: stay on main; R8 forced low
    6'b1100_10, // R2 both flags: enter battery
    6'b1000_10, // R6 battery drops below supply: still in battery
    6'b0100_11, // R6 between thresholds: hold; R8 warning resumes
    6'b0110_01, // R5 recovery with battery high: back to main
    6'b1101_10, // R2 second entry
    6'b0011_00, // R5 recovery with battery low: back to main
    6'b0010_01  // R7 release again
  };
  localparam int VREQ [NV] = '{7, 3, 7, 4, 2, 6, 6, 5, 2, 5, 7};

  task automatic check(input int req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] f);
    @(negedge clk);
    {below_sw, batt_hi, above_rst, pfi_low} = f;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, batt_sel, 1'b0, "reset batt_sel");  // R1
    check(1, pfail_n, 1'b0, "reset pfail_n");    // R1
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][5:2]);
      repeat (4) @(negedge clk);
      check(VREQ[i], batt_sel, VEC[i][1], $sformatf("vec %0d batt_sel", i));
      check(VREQ[i], pfail_n, VEC[i][0], $sformatf("vec %0d pfail_n", i));
    end

    // R9: latency is three rising edges
    drive(4'b0011);
    repeat (2) @(negedge clk);
    check(9, pfail_n, 1'b1, "two edges after change");
    @(negedge clk);
    check(9, pfail_n, 1'b0, "three edges after change");
    drive(4'b1100);
    repeat (2) @(negedge clk);
    check(9, batt_sel, 1'b0, "entry two edges");
    @(negedge clk);
    check(9, batt_sel, 1'b1, "entry three edges");

    // R1: reset in battery mode returns to main
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, batt_sel, 1'b0, "mid-run reset batt_sel");
    check(1, pfail_n, 1'b0, "mid-run reset pfail_n");
    drive(4'b0010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: battery removal and reinsertion during normal operation
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      batt_hi = k[1];
      above_rst = k[2];
      check(10, batt_sel, 1'b0, $sformatf("toggle %0d", k));
    end
    repeat (4) @(negedge clk);
    check(10, batt_sel, 1'b0, "after toggling");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule